// File: doc/BRIEF.md
# Selective processor state-save sequencer

This block sequences a partial save of processor state into a memory save area. When `start` is pulsed while the block is idle, it forms a 64-bit request operand from two operand registers. It masks that operand with the enabled-feature register and captures everything the save needs. It then walks three state components in a fixed order: the floating-point stack, the 128-bit vector registers and the upper halves of the 256-bit vectors. For each component it either issues a region-write command or passes it over. The walk continues with the vector control/status word and ends with a rewrite of the save-area header bit-vector.

An unmodified component may be left unwritten, but only when the current save context matches the context recorded at the most recent restore. The current context is the privilege level, the guest-mode flag and the linear address of the save area, with a compaction mask of zero. The record comes in on stub inputs. The number of components left unwritten this way is reported, so that the skip path can be checked against an arithmetic model. Commands leave on a valid/ready port. The command carries a kind code, and the header command also carries the merged header value.

Top module: `state_save_seq`

## Requirements
- R1: The effective request mask is `feat_en` AND {`req_hi`[31:0], `req_lo`[31:0]}; bits 63:32 of both operand registers have no effect on any command, header value or skip count.
- R2: The skip path is enabled only when `cur_priv` == `rec_priv`, `cur_guest` == `rec_guest` (1 = running as a virtualization guest), `area_addr` == `rec_addr` and `rec_cmask` == 0; any single mismatch disables it.
- R3: For component i in 0..2 (kind codes 0 = floating-point stack, 1 = 128-bit vectors, 2 = upper vector halves), a write of kind i is issued exactly when mask bit i and `inuse`[i] are 1, unless the skip path is enabled and `modified`[i] is 0.
- R4: A control/status write (kind 3) is issued whenever mask bit 1 or mask bit 2 is 1, whatever `inuse` and `modified` hold.
- R5: The header command (kind 4) is always issued, and its `cmd_data` equals (`old_hdr` AND NOT mask) OR (`inuse` AND mask).
- R6: Accepted commands follow strictly increasing kind order, and the header is the last command of every save.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_kind` and `cmd_data` hold their values into the next cycle.
- R8: `done` is high for exactly one cycle, the cycle after the header command is accepted; `busy` is high from the cycle after `start` until `done` falls.
- R9: `skip_cnt` equals the number of components left unwritten by the skip rule of R3, and holds that value until the next accepted `start`.
- R10: Inputs are captured when `start` is accepted; `start` while busy, and input changes after capture, have no effect on the current save.
- R11: After reset the block is idle: `cmd_valid`, `done` and `busy` are 0 and `skip_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a save when idle |
| req_hi | input | 64 | Operand register, high half of request |
| req_lo | input | 64 | Operand register, low half of request |
| feat_en | input | 64 | Enabled-feature register |
| inuse | input | 64 | Per-component in-use bitmap |
| modified | input | 64 | Per-component modified-since-restore bitmap |
| old_hdr | input | 64 | Header bit-vector read from the save area |
| cur_priv | input | 2 | Current privilege level |
| cur_guest | input | 1 | 1 when running as a virtualization guest |
| area_addr | input | 48 | Linear address of the save area |
| rec_priv | input | 2 | Privilege level recorded at last restore |
| rec_guest | input | 1 | Guest flag recorded at last restore |
| rec_addr | input | 48 | Area address recorded at last restore |
| rec_cmask | input | 64 | Compaction mask recorded at last restore |
| cmd_valid | output | 1 | Region-write command valid |
| cmd_ready | input | 1 | Memory side accepts the command |
| cmd_kind | output | 3 | Command kind code (0..4) |
| cmd_data | output | 64 | Merged header on kind 4, zero otherwise |
| busy | output | 1 | A save is in progress |
| done | output | 1 | One-cycle completion pulse |
| skip_cnt | output | 2 | Components skipped in the last save |

## Verification
The assertions assume only that reset is not applied in the middle of a save and that `cmd_ready` is a defined level in every cycle. They assume nothing about when ready arrives or about the mask, bitmap and context inputs. The stimulus keeps reset high through each whole save. It drives `cmd_ready` both continuously high and in an irregular stall pattern. It sweeps every combination of the three low request bits, in-use bits and modified bits against matching and mismatching contexts, and fills the ignored upper operand bits with random values. On some saves it scrambles the inputs and re-pulses `start` after capture.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
   typedef enum logic [2:0] {
      CK_FPU = 3'd0,
      CK_VEC = 3'd1,
      CK_UPV = 3'd2,
      CK_CSR = 3'd3,
      CK_HDR = 3'd4
   } ssq_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } ssq_state_e;

   localparam int unsigned SSQ_NCOMP = 3;
   localparam int unsigned SSQ_NSTEP = 5;
endpackage

// File: rtl/ssq_mask_calc.sv
module ssq_mask_calc #(
   parameter int unsigned MASK_W = 64,
   parameter int unsigned REG_W  = 64
) (
   input  logic [REG_W-1:0]  req_hi,
   input  logic [REG_W-1:0]  req_lo,
   input  logic [MASK_W-1:0] feat_en,
   input  logic [MASK_W-1:0] inuse,
   input  logic [MASK_W-1:0] old_hdr,
   output logic [MASK_W-1:0] rmask,
   output logic [MASK_W-1:0] new_hdr
);
   localparam int unsigned HALF_W = MASK_W / 2;

   if (REG_W < HALF_W) begin : g_bad_reg
      $error("REG_W must cover half of MASK_W");
   end

   logic [MASK_W-1:0] operand;

   // only the low half of each operand register contributes
   assign operand = {req_hi[HALF_W-1:0], req_lo[HALF_W-1:0]};
   assign rmask   = operand & feat_en;
   assign new_hdr = (old_hdr & ~rmask) | (inuse & rmask);
endmodule

// File: rtl/ssq_ctx_match.sv
module ssq_ctx_match #(
   parameter int unsigned PRIV_W = 2,
   parameter int unsigned ADDR_W = 48,
   parameter int unsigned MASK_W = 64,
   parameter bit          OPT_EN = 1'b1
) (
   input  logic [PRIV_W-1:0] cur_priv,
   input  logic              cur_guest,
   input  logic [ADDR_W-1:0] area_addr,
   input  logic [PRIV_W-1:0] rec_priv,
   input  logic              rec_guest,
   input  logic [ADDR_W-1:0] rec_addr,
   input  logic [MASK_W-1:0] rec_cmask,
   output logic              opt_ok
);
   if (OPT_EN) begin : g_match
      logic same_priv, same_guest, same_addr, zero_cmask;
      assign same_priv  = (cur_priv == rec_priv);
      assign same_guest = (cur_guest == rec_guest);
      assign same_addr  = (area_addr == rec_addr);
      // the current save always uses an uncompacted layout
      assign zero_cmask = (rec_cmask == '0);
      assign opt_ok     = same_priv & same_guest & same_addr & zero_cmask;
   end else begin : g_nomatch
      logic unused_ok;
      assign unused_ok = ^{cur_priv, cur_guest, area_addr,
                           rec_priv, rec_guest, rec_addr, rec_cmask};
      assign opt_ok    = 1'b0;
   end
endmodule

// File: rtl/ssq_plan.sv
module ssq_plan
   import ssq_pkg::*;
#(
   parameter int unsigned CNT_W = 2
) (
   input  logic [SSQ_NCOMP-1:0] rmask_lo,
   input  logic [SSQ_NCOMP-1:0] inuse_lo,
   input  logic [SSQ_NCOMP-1:0] mod_lo,
   input  logic                 opt_ok,
   output logic [SSQ_NSTEP-1:0] need,
   output logic [CNT_W-1:0]     skip_n
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must hold a count up to three");
   end

   logic [SSQ_NCOMP-1:0] hit;
   logic [SSQ_NCOMP-1:0] sup;

   for (genvar g = 0; g < SSQ_NCOMP; g++) begin : g_comp
      assign hit[g]  = rmask_lo[g] & inuse_lo[g];
      assign sup[g]  = hit[g] & opt_ok & ~mod_lo[g];
      assign need[g] = hit[g] & ~sup[g];
   end

   assign need[3] = rmask_lo[1] | rmask_lo[2];
   assign need[4] = 1'b1;

   always_comb begin
      skip_n = '0;
      for (int i = 0; i < SSQ_NCOMP; i++) begin
         skip_n = skip_n + CNT_W'(sup[i]);
      end
   end
endmodule

// File: rtl/state_save_seq.sv
module state_save_seq
   import ssq_pkg::*;
#(
   parameter int unsigned MASK_W = 64,
   parameter int unsigned REG_W  = 64,
   parameter int unsigned PRIV_W = 2,
   parameter int unsigned ADDR_W = 48,
   parameter int unsigned CNT_W  = 2,
   parameter bit          OPT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [REG_W-1:0]  req_hi,
   input  logic [REG_W-1:0]  req_lo,
   input  logic [MASK_W-1:0] feat_en,
   input  logic [MASK_W-1:0] inuse,
   input  logic [MASK_W-1:0] modified,
   input  logic [MASK_W-1:0] old_hdr,
   input  logic [PRIV_W-1:0] cur_priv,
   input  logic              cur_guest,
   input  logic [ADDR_W-1:0] area_addr,
   input  logic [PRIV_W-1:0] rec_priv,
   input  logic              rec_guest,
   input  logic [ADDR_W-1:0] rec_addr,
   input  logic [MASK_W-1:0] rec_cmask,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [2:0]        cmd_kind,
   output logic [MASK_W-1:0] cmd_data,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  skip_cnt
);
   localparam logic [2:0] K_HDR = 3'(CK_HDR);

   if (MASK_W < SSQ_NCOMP || (MASK_W % 2) != 0) begin : g_bad_mask
      $error("MASK_W must be even and cover all components");
   end
   if (ADDR_W == 0 || PRIV_W == 0) begin : g_bad_ctx
      $error("context widths must be non-zero");
   end

   logic [MASK_W-1:0]    rmask_c, hdr_c;
   logic                 opt_c;
   logic [SSQ_NSTEP-1:0] need_c;
   logic [CNT_W-1:0]     skip_c;

   ssq_mask_calc #(.MASK_W(MASK_W), .REG_W(REG_W)) u_mask (
      .req_hi (req_hi),
      .req_lo (req_lo),
      .feat_en(feat_en),
      .inuse  (inuse),
      .old_hdr(old_hdr),
      .rmask  (rmask_c),
      .new_hdr(hdr_c)
   );

   ssq_ctx_match #(.PRIV_W(PRIV_W), .ADDR_W(ADDR_W), .MASK_W(MASK_W),
                   .OPT_EN(OPT_EN)) u_ctx (
      .cur_priv (cur_priv),
      .cur_guest(cur_guest),
      .area_addr(area_addr),
      .rec_priv (rec_priv),
      .rec_guest(rec_guest),
      .rec_addr (rec_addr),
      .rec_cmask(rec_cmask),
      .opt_ok   (opt_c)
   );

   ssq_plan #(.CNT_W(CNT_W)) u_plan (
      .rmask_lo(rmask_c[SSQ_NCOMP-1:0]),
      .inuse_lo(inuse[SSQ_NCOMP-1:0]),
      .mod_lo  (modified[SSQ_NCOMP-1:0]),
      .opt_ok  (opt_c),
      .need    (need_c),
      .skip_n  (skip_c)
   );

   ssq_state_e           state;
   logic [2:0]           step;
   logic [SSQ_NSTEP-1:0] need_q;
   logic [MASK_W-1:0]    hdr_q;
   logic [CNT_W-1:0]     skip_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         step   <= '0;
         need_q <= '0;
         hdr_q  <= '0;
         skip_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  need_q <= need_c;
                  hdr_q  <= hdr_c;
                  skip_q <= skip_c;
                  step   <= '0;
                  state  <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (need_q[step]) begin
                  if (cmd_ready) begin
                     if (step == K_HDR) state <= ST_FIN;
                     else               step  <= step + 3'd1;
                  end
               end else begin
                  step <= step + 3'd1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cmd_valid = (state == ST_RUN) && need_q[step];
   assign cmd_kind  = step;
   assign cmd_data  = (step == K_HDR) ? hdr_q : '0;
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_FIN);
   assign skip_cnt  = skip_q;

   // checker state: last accepted kind within the current save
   logic [2:0] last_acc;
   logic       any_acc;
   logic       acc;
   assign acc = cmd_valid && cmd_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_acc <= '0;
         any_acc  <= 1'b0;
      end else if (!busy && start) begin
         any_acc  <= 1'b0;
      end else if (acc) begin
         last_acc <= cmd_kind;
         any_acc  <= 1'b1;
      end
   end

   // R7
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=>
         (cmd_valid && $stable(cmd_kind) && $stable(cmd_data)));

   // R8
   done_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_kind == K_HDR) |=> done);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   kind_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && any_acc) |-> (cmd_kind > last_acc));

   // R6
   hdr_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_kind == K_HDR) |=> !cmd_valid);
endmodule

// File: tb/tb_state_save_seq.sv
module tb_state_save_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] req_hi = '0, req_lo = '0, feat_en = '0, inuse = '0;
   logic [63:0] modified = '0, old_hdr = '0, rec_cmask = '0;
   logic [1:0]  cur_priv = '0, rec_priv = '0;
   logic        cur_guest = 1'b0, rec_guest = 1'b0;
   logic [47:0] area_addr = '0, rec_addr = '0;
   logic        cmd_valid, busy, done;
   logic        cmd_ready = 1'b0;
   logic [2:0]  cmd_kind;
   logic [63:0] cmd_data;
   logic [1:0]  skip_cnt;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   state_save_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_hi(req_hi), .req_lo(req_lo), .feat_en(feat_en),
      .inuse(inuse), .modified(modified), .old_hdr(old_hdr),
      .cur_priv(cur_priv), .cur_guest(cur_guest), .area_addr(area_addr),
      .rec_priv(rec_priv), .rec_guest(rec_guest), .rec_addr(rec_addr),
      .rec_cmask(rec_cmask),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
      .cmd_data(cmd_data), .busy(busy), .done(done), .skip_cnt(skip_cnt)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: sample and drive ready at the falling edge
   int          cyc = 0;
   bit          stall_mode = 1'b0;
   int          rec_n = 0;
   logic [2:0]  rec_k [8];
   logic [63:0] rec_hdr = '0;
   bit          hdr_prev = 1'b0;
   bit          done_seen = 1'b0;
   int          done_cnt = 0;
   bit          pend = 1'b0;
   logic [2:0]  pend_kind = '0;
   logic [63:0] pend_data = '0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (hdr_prev) chk(done == 1'b1, "R8 done after header", 64'(done), 64'd1);
         else          chk(done == 1'b0, "R8 done single pulse", 64'(done), 64'd0);
         hdr_prev = 1'b0;
         if (done) begin done_seen = 1'b1; done_cnt++; end
         if (pend) chk(cmd_valid && cmd_kind == pend_kind && cmd_data == pend_data,
                       "R7 hold under stall", cmd_data, pend_data);
         cmd_ready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
         if (cmd_valid && cmd_ready) begin
            if (rec_n < 8) rec_k[rec_n] = cmd_kind;
            rec_n++;
            if (cmd_kind == 3'd4) begin
               rec_hdr  = cmd_data;
               hdr_prev = 1'b1;
            end
         end
         pend      = cmd_valid && !cmd_ready;
         pend_kind = cmd_kind;
         pend_data = cmd_data;
      end
   end

   task automatic run_op(input logic [2:0] r, input logic [2:0] iu,
                         input logic [2:0] md, input bit match,
                         input int sel, input bit scramble);
      logic [63:0] rqh, rql, fe, iuv, mdv, oh, rcm, rm, exp_hdr;
      logic [1:0]  pv, rpv;
      logic        gs, rgs;
      logic [47:0] ad, rad;
      bit          opt;
      int          exp_k [6];
      int          exp_n;
      int          exp_skip;
      int          waited;
      bit          seq_ok;

      rqh = {$urandom, $urandom};
      rql = {$urandom, $urandom};
      rql[2:0] = r;
      fe  = {$urandom, $urandom};
      fe[2:0] = (sel % 3 == 0) ? 3'($urandom) : 3'b111;
      iuv = {$urandom, $urandom}; iuv[2:0] = iu;
      mdv = {$urandom, $urandom}; mdv[2:0] = md;
      oh  = {$urandom, $urandom};
      pv = 2'($urandom); gs = 1'($urandom); ad = {16'($urandom), $urandom};
      rpv = pv; rgs = gs; rad = ad; rcm = '0;
      if (!match) begin
         case (sel % 4)
            0: rpv = pv + 2'd1;
            1: rgs = ~gs;
            2: rad = ad ^ (48'd1 << (sel % 48));
            default: rcm = 64'd1 << (sel % 64);
         endcase
      end

      // expected values (R1..R5, R9)
      rm      = {rqh[31:0], rql[31:0]} & fe;
      exp_hdr = (oh & ~rm) | (iuv & rm);
      opt     = (pv == rpv) && (gs == rgs) && (ad == rad) && (rcm == '0);
      exp_n = 0; exp_skip = 0;
      for (int i = 0; i < 3; i++) begin
         if (rm[i] && iuv[i]) begin
            if (opt && !mdv[i]) exp_skip++;
            else begin exp_k[exp_n] = i; exp_n++; end
         end
      end
      if (rm[1] || rm[2]) begin exp_k[exp_n] = 3; exp_n++; end
      exp_k[exp_n] = 4; exp_n++;

      @(posedge clk); #2;
      req_hi = rqh; req_lo = rql; feat_en = fe; inuse = iuv; modified = mdv;
      old_hdr = oh; cur_priv = pv; cur_guest = gs; area_addr = ad;
      rec_priv = rpv; rec_guest = rgs; rec_addr = rad; rec_cmask = rcm;
      start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
      chk(busy == 1'b1, "R8 busy after start", 64'(busy), 64'd1);
      if (scramble) begin
         // R10: captured values must survive a garbage re-start
         req_hi = ~rqh; req_lo = ~rql; feat_en = ~fe; inuse = ~iuv;
         modified = ~mdv; old_hdr = ~oh; rec_cmask = 64'hFF;
         start = 1'b1;
         @(posedge clk); #2;
         start = 1'b0;
      end

      waited = 0;
      while (!done_seen && waited < 60) begin
         @(posedge clk); #2;
         waited++;
      end
      chk(done_seen, "R8 save completes", 64'(done_seen), 64'd1);

      seq_ok = (rec_n == exp_n);
      for (int i = 0; i < 6; i++)
         if (seq_ok && i < exp_n && rec_k[i] != 3'(exp_k[i])) seq_ok = 1'b0;
      chk(seq_ok, scramble ? "R10 R3 R4 R6 command sequence"
                           : "R1 R2 R3 R4 R6 command sequence",
          64'(rec_n), 64'(exp_n));
      chk(rec_hdr == exp_hdr, "R5 R1 header merge", rec_hdr, exp_hdr);
      @(posedge clk); #2;
      chk(skip_cnt == 2'(exp_skip), "R9 skip count", 64'(skip_cnt), 64'(exp_skip));
      chk(busy == 1'b0 && done_cnt == 1, "R8 busy drops, one done",
          64'(done_cnt), 64'd1);
      rec_n = 0; done_seen = 1'b0; done_cnt = 0;
   endtask

   initial begin
      #1500000;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk); #2;
      // R11 reset state
      chk(cmd_valid == 1'b0, "R11 no command after reset", 64'(cmd_valid), 64'd0);
      chk(done == 1'b0, "R11 done low after reset", 64'(done), 64'd0);
      chk(busy == 1'b0, "R11 idle after reset", 64'(busy), 64'd0);
      chk(skip_cnt == 2'd0, "R11 skip count zero", 64'(skip_cnt), 64'd0);

      n = 0;
      for (int r = 0; r < 8; r++)
         for (int iu = 0; iu < 8; iu++)
            for (int md = 0; md < 8; md++)
               for (int m = 0; m < 2; m++) begin
                  stall_mode = (n % 2) == 1;
                  run_op(3'(r), 3'(iu), 3'(md), m == 1, n, (n % 7) == 3);
                  n++;
               end

      // R9 skip count held while idle
      repeat (5) @(posedge clk);
      #2;
      chk(busy == 1'b0 && cmd_valid == 1'b0, "R9 R10 idle stays quiet",
          64'(cmd_valid), 64'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule